// File: doc/BRIEF.md
# Serial FPGA configuration loader

This block loads a configuration bitstream into a downstream programmable device over a one-bit serial link. A single start pulse begins a load. The block first pulls the device's active-low program line and waits for the device to signal that its memory is clearing. After a short setup hold it releases program and waits for the device to report that it is ready. It then shifts the bytes it takes from a valid/ready byte stream onto a data line, under a configuration clock that it generates itself.

Between bytes the block checks the device's init and done lines for a CRC error. After the byte flagged as last, it holds the data line high and keeps clocking until the device raises done. Each load ends with exactly one of three one-cycle result pulses: success, timeout or CRC error. A readback request always gets a failure pulse, because the serial link carries no return data.

All cycle counts are in system-clock cycles: the half-period of the configuration clock, the program setup hold and the timeout of each wait phase.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start pulse in idle drives prog_n_o low on the next cycle. If init_n_i has not gone low within TIMEOUT_CYC cycles, tmo_o pulses exactly TIMEOUT_CYC cycles after prog_n_o first reads low, and the configuration clock stays high while prog_n_o is low.
- R2: Once init_n_i is seen low, prog_n_o stays low for SETUP_CYC more cycles and then goes high. A fresh timeout of TIMEOUT_CYC cycles then runs while the block waits for init_n_i to return high.
- R3: Before each byte is accepted, if init_n_i is low while done_i is low, crc_o pulses, the load ends and no further byte is accepted or shifted.
- R4: Each accepted byte goes out as 8 serial bits, bit 7 first and bit 0 last.
- R5: For each bit, cclk_o is low for HALF_CYC cycles while dout_o carries the bit, then high for HALF_CYC cycles. dout_o does not change on a rising edge of cclk_o.
- R6: After the byte marked by byte_last_i has been shifted, dout_o is held at 1 and cclk_o keeps toggling. The first cycle in which done_i is seen high ends the load with an ok_o pulse. If done_i does not rise within TIMEOUT_CYC cycles, the load ends with tmo_o.
- R7: A readback request pulse on rdbk_req_i gives a one-cycle rdbk_fail_o pulse on the next cycle and leaves prog_n_o, busy_o and the load untouched.
- R8: byte_ready_o is high only while the shift register is empty and a load is in its data phase. While no byte is offered, cclk_o is held high, and this wait has no timeout.
- R9: busy_o is high from the cycle after start until the result. The result pulse (ok_o, tmo_o or crc_o) lasts one cycle and appears in the same cycle in which busy_o falls.
- R10: A start pulse while busy_o is high is ignored. It neither restarts the load nor triggers a second load after the first one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-load pulse |
| rdbk_req_i | input | 1 | Readback request pulse (always refused) |
| byte_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_last_i | input | 1 | byte_i is the final byte of the bitstream |
| byte_ready_o | output | 1 | Block accepts byte_i this cycle |
| prog_n_o | output | 1 | Active-low program line to the device |
| cclk_o | output | 1 | Configuration clock; the device samples on its rising edge |
| dout_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Device init line, active low |
| done_i | input | 1 | Device done line |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | One-cycle success pulse |
| tmo_o | output | 1 | One-cycle timeout pulse |
| crc_o | output | 1 | One-cycle CRC-error pulse |
| rdbk_fail_o | output | 1 | One-cycle readback-refused pulse |

## Verification
The bench models the device. It measures the timeout cycle count in both init phases, so a counter that does not restart between phases, or is off by one, shows up as a wrong cycle count or as the wrong phase timing out. It drives init low in the middle of a load to check that a misplaced CRC check would either accept one byte too many or miss the error. It rebuilds every byte from the rising edges of cclk_o, which catches LSB-first shifting, a dropped bit and data that changes on the sampling edge. It checks that the trailing clocks after the last byte all carry a 1, and it fires a start pulse in the middle of a load, where a controller that re-arms on it would lower program again after the result.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int HALF_CYC    = 2,
  parameter int SETUP_CYC   = 4,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rdbk_req_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       dout_o,
  input  logic       init_n_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic       tmo_o,
  output logic       crc_o,
  output logic       rdbk_fail_o
);

  localparam int PMAX = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [PW-1:0] HALF_LAST  = PW'(HALF_CYC - 1);
  localparam logic [PW-1:0] SETUP_LAST = PW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST   = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_SETUP, S_RISE, S_FETCH, S_SHIFT, S_FLUSH
  } st_t;

  st_t           st;
  logic [PW-1:0] pc;
  logic [TW-1:0] tcnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          hi, last_r;

  logic crc_hit, tmo_hit, half_end;
  assign crc_hit  = !init_n_i && !done_i;
  assign tmo_hit  = (tcnt == TMO_LAST);
  assign half_end = (pc == HALF_LAST);

  assign busy_o       = (st != S_IDLE);
  assign prog_n_o     = !(st == S_PROG || st == S_SETUP);
  assign cclk_o       = !((st == S_SHIFT || st == S_FLUSH) && !hi);
  assign dout_o       = (st == S_SHIFT) ? sh[7] : 1'b1;
  assign byte_ready_o = (st == S_FETCH) && !crc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pc          <= '0;
      tcnt        <= '0;
      sh          <= '0;
      bitn        <= '0;
      hi          <= 1'b0;
      last_r      <= 1'b0;
      ok_o        <= 1'b0;
      tmo_o       <= 1'b0;
      crc_o       <= 1'b0;
      rdbk_fail_o <= 1'b0;
    end else begin
      ok_o        <= 1'b0;
      tmo_o       <= 1'b0;
      crc_o       <= 1'b0;
      rdbk_fail_o <= rdbk_req_i;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            st   <= S_PROG;
            tcnt <= '0;
          end
        end
        S_PROG: begin
          if (!init_n_i) begin
            st <= S_SETUP;
            pc <= '0;
          end else if (tmo_hit) begin
            tmo_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_SETUP: begin
          if (pc == SETUP_LAST) begin
            st   <= S_RISE;
            tcnt <= '0;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        S_RISE: begin
          if (init_n_i) begin
            st <= S_FETCH;
          end else if (tmo_hit) begin
            tmo_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_FETCH: begin
          if (crc_hit) begin
            crc_o <= 1'b1;
            st    <= S_IDLE;
          end else if (byte_valid_i) begin
            sh     <= byte_i;
            last_r <= byte_last_i;
            bitn   <= '0;
            hi     <= 1'b0;
            pc     <= '0;
            st     <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (half_end) begin
            pc <= '0;
            hi <= !hi;
            if (hi) begin
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) begin
                if (last_r) begin
                  st   <= S_FLUSH;
                  tcnt <= '0;
                  hi   <= 1'b0;
                end else begin
                  st <= S_FETCH;
                end
              end
            end
          end else begin
            pc <= pc + 1'b1;
          end
        end
        S_FLUSH: begin
          if (done_i) begin
            ok_o <= 1'b1;
            st   <= S_IDLE;
          end else if (tmo_hit) begin
            tmo_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
            if (half_end) begin
              pc <= '0;
              hi <= !hi;
            end else begin
              pc <= pc + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_ready_o,
  input logic prog_n_o,
  input logic cclk_o,
  input logic dout_o,
  input logic init_n_i,
  input logic done_i,
  input logic busy_o,
  input logic ok_o,
  input logic tmo_o,
  input logic crc_o
);

  // R1
  prog_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> cclk_o);

  // R3
  crc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_o |-> $past(!init_n_i && !done_i));

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(dout_o));

  // R6
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> $past(done_i));

  // R8
  ready_idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && prog_n_o && cclk_o));

  // R9
  result_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o || tmo_o || crc_o) |-> (!busy_o && $past(busy_o)));

  // R9
  result_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o || tmo_o || crc_o) |=> !(ok_o || tmo_o || crc_o));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (.*);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  localparam int HALF = 2;
  localparam int SETUP = 3;
  localparam int TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, rdbk_req_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic byte_valid_i = 1'b0, byte_last_i = 1'b0;
  logic init_n_i = 1'b1, done_i = 1'b0;
  logic byte_ready_o, prog_n_o, cclk_o, dout_o, busy_o, ok_o, tmo_o, crc_o, rdbk_fail_o;

  int nchk = 0, nerr = 0;
  logic [7:0] exp_b [0:15];

  always #2.5 clk = ~clk;

  cfg_serial_loader #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) u0 (.*);

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!c) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode: 0 normal, 1 init never low, 2 init never back high, 3 crc after k bytes, 4 done never
  function automatic int exp_res(input int mode);
    case (mode)
      0: return 0;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_acc(input int mode, input int n, input int k);
    if (mode == 1 || mode == 2) return 0;
    if (mode == 3) return k;
    return n;
  endfunction

  task automatic run_case(input int n, input int mode, input int k, input bit poke);
    int idx, cyc, ncap, res, cyc_prog, cyc_rel, cyc_ilo, cyc_res, lo_cnt, hi_cnt, dlo, dhi, de, bad, ones_bad;
    bit hs, prev_cclk, busy_bad, crc_on;
    bit cap [0:255];
    idx = 0; cyc = 0; ncap = 0; res = -1; cyc_prog = -1; cyc_rel = -1; cyc_ilo = -1; cyc_res = 0;
    lo_cnt = 0; hi_cnt = 0; hs = 0; prev_cclk = 1; busy_bad = 0; crc_on = 0;
    dlo = 2 + int'($urandom % 6); dhi = 2 + int'($urandom % 6); de = 1 + int'($urandom % 4);
    for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
    init_n_i = 1'b1; done_i = 1'b0;
    @(negedge clk); start_i = 1'b1;
    while (res < 0 && cyc < 6000) begin
      @(negedge clk); cyc++;
      if (hs) idx++;
      start_i = poke && (cyc == 60);
      if (!prog_n_o && cyc_prog < 0) cyc_prog = cyc;
      if (prog_n_o && cyc_prog >= 0 && cyc_rel < 0) cyc_rel = cyc;
      if (cclk_o && !prev_cclk) begin
        if (ncap < 256) cap[ncap] = dout_o;
        ncap++;
      end
      prev_cclk = cclk_o;
      if (ok_o) res = 0; else if (tmo_o) res = 1; else if (crc_o) res = 2;
      if (res >= 0) cyc_res = cyc;
      else if (!busy_o) busy_bad = 1;
      if (cyc_prog >= 0 && cyc_rel < 0 && init_n_i && mode != 1 && cyc_ilo < 0) begin
        lo_cnt++;
        if (lo_cnt >= dlo) begin init_n_i = 1'b0; cyc_ilo = cyc; end
      end
      if (cyc_rel >= 0 && !init_n_i && mode != 2 && !crc_on) begin
        hi_cnt++;
        if (hi_cnt >= dhi) init_n_i = 1'b1;
      end
      if (mode == 3 && idx >= k && cyc_rel >= 0 && init_n_i) begin init_n_i = 1'b0; crc_on = 1; end
      if (mode == 0 && ncap >= 8*n + de) done_i = 1'b1;
      byte_valid_i = (idx < n) && ($urandom % 4 != 0);
      byte_i = (idx < n) ? exp_b[idx] : 8'h00;
      byte_last_i = (idx == n - 1);
      #1;
      hs = byte_valid_i && byte_ready_o;
    end
    byte_valid_i = 1'b0; start_i = 1'b0;
    chk(res == exp_res(mode), "R1/R2/R3/R6", $sformatf("result code mode %0d", mode), res, exp_res(mode));
    chk(idx == exp_acc(mode, n, k), "R3/R8", "bytes accepted", idx, exp_acc(mode, n, k));
    bad = 0;
    for (int i = 0; i < 8*idx && i < ncap; i++)
      if (cap[i] != exp_b[i/8][7 - (i%8)]) bad++;
    chk(bad == 0 && ncap >= 8*idx, "R4/R5", "serial bit mismatches", bad, 0);
    chk(!busy_bad, "R9", "busy low before result", int'(busy_bad), 0);
    if (mode == 0 || mode == 4) begin
      ones_bad = 0;
      for (int i = 8*n; i < ncap && i < 256; i++) if (!cap[i]) ones_bad++;
      chk(ones_bad == 0, "R6", "zero bits in trailing clocks", ones_bad, 0);
    end
    if (mode == 0) chk(ncap - 8*n >= de, "R6", "trailing clock edges", ncap - 8*n, de);
    if (mode == 3) chk(ncap == 8*k, "R3", "bits shifted after crc", ncap, 8*k);
    if (mode == 1) chk(cyc_res - cyc_prog == TMO, "R1", "init-low timeout cycles", cyc_res - cyc_prog, TMO);
    if (mode == 2) chk(cyc_res - cyc_rel == TMO, "R2", "init-high timeout cycles", cyc_res - cyc_rel, TMO);
    if (mode != 1) chk(cyc_rel - cyc_ilo == SETUP + 1, "R2", "program hold after init low", cyc_rel - cyc_ilo, SETUP + 1);
    @(negedge clk);
    chk(!(ok_o || tmo_o || crc_o), "R9", "result pulse width", int'(ok_o | tmo_o | crc_o), 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(!busy_o && prog_n_o, "R10", "restart after ignored start", int'(busy_o), 0);
    end
    init_n_i = 1'b1; done_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && prog_n_o && cclk_o && !byte_ready_o && !(ok_o|tmo_o|crc_o), "R9", "reset state", int'(busy_o), 0);
    // R7 readback refused
    rdbk_req_i = 1'b1; @(negedge clk); rdbk_req_i = 1'b0;
    chk(rdbk_fail_o && !busy_o && prog_n_o, "R7", "readback refused", int'(rdbk_fail_o), 1);
    @(negedge clk);
    chk(!rdbk_fail_o, "R7", "readback pulse width", int'(rdbk_fail_o), 0);
    run_case(2, 1, 0, 0);   // R1 timeout
    run_case(2, 2, 0, 0);   // R2 timeout
    run_case(3, 3, 1, 0);   // R3 crc after first byte
    run_case(1, 0, 0, 0);   // R6 single byte
    run_case(4, 0, 0, 1);   // R10 start mid-load
    run_case(3, 4, 0, 0);   // R6 done timeout
    for (int t = 0; t < 10; t++) begin
      int n = 2 + int'($urandom % 5);
      int m = ($urandom % 3 == 0) ? 3 : 0;
      run_case(n, m, 1 + int'($urandom % (n - 1)), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule